// File: doc/BRIEF.md
# Per-Processor Interrupt Priority Gate

This block is the delivery stage that sits between the interrupt sources of a controller and one processor. Each cycle it can take one source event: a source index, whether that source has just become active or inactive, its 4-bit priority, and the output class it is routed to. Sources of the normal class are held in a raised set. The gate compares the highest raised priority with a processor-owned task-priority threshold and with the highest priority among the sources the processor is servicing, and then decides whether the normal interrupt line rises, drops or holds.

Sources routed to the critical or machine-check class skip all priority logic. Each of these two lines is driven by a count of active sources on that class. The line is high while the count is non-zero. The task-priority threshold can be rewritten at any time, and the gate re-evaluates the normal line against the new value. The in-service set arrives as a bitmap from the acknowledge logic. The gate also reports the raised source it would hand over next.

Top module: `irq_prio_gate`

## Requirements
- R1: A normal-class activation is always added to the raised set, whatever its priority. A normal-class deactivation always removes the source. The set is observable through `next_valid`, `next_src` and `next_prio`.
- R2: A normal-class activation with priority less than or equal to the task priority never asserts `irq_norm`. In that case the line holds only if the highest raised priority exceeds both the task priority and the highest in-service priority; otherwise it drops.
- R3: A normal-class activation above the task priority asserts `irq_norm` unless the in-service set is non-empty and the new priority is at or below the highest in-service priority. In that case the line is left unchanged.
- R4: On a normal-class deactivation, `irq_norm` holds only if the highest remaining raised priority is above both the task priority and the highest in-service priority. Otherwise it drops.
- R5: A task-priority write keeps bits [3:0] of `tpr_wdata`. If the highest raised priority (0 when the set is empty) is at or below the new value, `irq_norm` drops. Otherwise, if it is above the highest in-service priority, the line rises. Otherwise the line holds.
- R6: Class code 1 (critical) and class code 2 (machine-check) ignore priority, task priority and in-service state. Each drives its own line (`irq_crit`, `irq_mchk`), which is high while at least one source of that class is active.
- R7: A per-class active count changes only on a real transition of a source: inactive to active, or active to inactive. A repeated activation or deactivation leaves it unchanged.
- R8: Among raised sources of equal highest priority, the lowest index is reported next. An empty set reports `next_valid`=0, `next_src` all ones and `next_prio`=0.
- R9: Reset (synchronous, active high) clears the raised set, the activity state and both counts. It drops all three lines, reports an empty next source and sets the task priority to 15.
- R10: An event whose index is at or above the source count, or whose class code is 3, has no effect on any output or state.
- R11: All outputs are registered and change on the edge that samples the event or write. When an event and a task-priority write arrive in the same cycle, the event's decision is made against the newly written task priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Source event present this cycle |
| ev_src | input | SRC_W | Source index of the event |
| ev_active | input | 1 | 1 = source became active, 0 = inactive |
| ev_prio | input | 4 | Source priority |
| ev_class | input | 2 | Output class: 0 normal, 1 critical, 2 machine-check, 3 ignored |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write data, low 4 bits kept |
| svc_map | input | N_SRC | In-service bitmap, one bit per source |
| irq_norm | output | 1 | Normal interrupt line |
| irq_crit | output | 1 | Critical interrupt line |
| irq_mchk | output | 1 | Machine-check interrupt line |
| tpr | output | 4 | Current task priority |
| next_valid | output | 1 | Raised set non-empty |
| next_src | output | SRC_W | Index of the highest-priority raised source |
| next_prio | output | 4 | Priority of that source |

## Verification
On every cycle, assertions check three things. A rising `irq_norm` always comes with a reported priority above the task priority and above the in-service priority. The class counts move by at most one per cycle and only switch their lines at one and zero. Ignored events leave the raised set untouched. Behaviour that depends on history can only be shown by the bench's scenarios. This covers a source hidden by in-service work and later released by a threshold write, ties resolved to the lowest index, repeated critical deactivations that must not underflow, and a threshold write that lands in the same cycle as an event.

// File: rtl/irq_prio_gate_pkg.sv
package irq_prio_gate_pkg;

    localparam int PRIO_W = 4;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_CRIT = 2'd1,
        CLS_MCHK = 2'd2,
        CLS_NONE = 2'd3
    } out_cls_e;

    typedef enum logic [1:0] {
        NDEC_HOLD  = 2'd0,
        NDEC_RAISE = 2'd1,
        NDEC_DROP  = 2'd2
    } norm_dec_e;

    typedef struct packed {
        logic  valid;
        prio_t prio;
    } pick_t;

    // Line stays only if the best raised level beats both threshold and in-service
    function automatic norm_dec_e deact_decide(prio_t rsd, prio_t svc, prio_t thr);
        if (rsd > thr && rsd > svc) return NDEC_HOLD;
        return NDEC_DROP;
    endfunction

    function automatic norm_dec_e act_decide(prio_t p, logic svc_vld, prio_t svc,
                                             prio_t thr, prio_t rsd);
        if (p <= thr)                return deact_decide(rsd, svc, thr);
        if (svc_vld && (p <= svc))   return NDEC_HOLD;
        return NDEC_RAISE;
    endfunction

    function automatic norm_dec_e thr_decide(prio_t rsd, prio_t svc, prio_t thr);
        if (rsd <= thr) return NDEC_DROP;
        if (rsd > svc)  return NDEC_RAISE;
        return NDEC_HOLD;
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_prio_gate_pkg::*;
#(
    parameter int N_SRC = 24,
    parameter int SRC_W = 5
) (
    input  logic [N_SRC-1:0]        map,
    input  logic [N_SRC*PRIO_W-1:0] prio_flat,
    output logic                    best_valid,
    output logic [SRC_W-1:0]        best_idx,
    output prio_t                   best_prio
);
    localparam logic [SRC_W-1:0] IDX_NONE = '1;

    // Strict greater-than keeps the lowest index on ties (R8)
    always_comb begin
        best_valid = 1'b0;
        best_idx   = IDX_NONE;
        best_prio  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (map[i] && (!best_valid || prio_flat[i*PRIO_W +: PRIO_W] > best_prio)) begin
                best_valid = 1'b1;
                best_idx   = SRC_W'(i);
                best_prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_class_counter.sv
module irq_class_counter #(
    parameter int N_SRC = 24,
    localparam int CNT_W = $clog2(N_SRC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic line_q
);
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    always_comb begin
        cnt_nx = cnt_q;
        if (inc && !dec)      cnt_nx = cnt_q + CNT_W'(1);
        else if (dec && !inc) cnt_nx = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            line_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            line_q <= (cnt_nx != '0);
        end
    end

    // R7: count moves by at most one step per cycle
    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |->
        ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q) - CNT_W'(1))));

    // R6: line rises only when the count reaches one
    a_r6_rise_at_one: assert property (@(posedge clk) disable iff (rst)
        $rose(line_q) |-> (cnt_q == CNT_W'(1)));

    // R6: line falls only when the count returns to zero
    a_r6_fall_at_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(line_q) |-> (cnt_q == '0));

    // R7: no decrement from an empty count
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_q) == '0) |-> (cnt_q <= CNT_W'(1)));

endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
    import irq_prio_gate_pkg::*;
#(
    parameter int N_SRC = 24,
    parameter int SRC_W = 5,
    parameter int TPR_DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [SRC_W-1:0]  ev_src,
    input  logic              ev_active,
    input  logic [3:0]        ev_prio,
    input  logic [1:0]        ev_class,
    input  logic              tpr_we,
    input  logic [TPR_DW-1:0] tpr_wdata,
    input  logic [N_SRC-1:0]  svc_map,
    output logic              irq_norm,
    output logic              irq_crit,
    output logic              irq_mchk,
    output logic [3:0]        tpr,
    output logic              next_valid,
    output logic [SRC_W-1:0]  next_src,
    output logic [3:0]        next_prio
);
    localparam int N_SPECIAL = 2;
    localparam logic [SRC_W-1:0] IDX_NONE = '1;
    localparam prio_t TPR_RST = '1;

    // ---------------- state ----------------
    logic [N_SRC-1:0]        raised_q, raised_nx;
    logic [N_SRC-1:0]        act_q, act_nx;
    logic [N_SRC*PRIO_W-1:0] prio_q, prio_nx;
    prio_t                   tpr_q, tpr_nx;
    logic                    norm_q;
    pick_t                   next_q;
    logic [SRC_W-1:0]        next_idx_q;

    // ---------------- event qualification ----------------
    logic     ev_ok;
    out_cls_e ev_cls;
    logic [N_SRC-1:0] ev_hit;
    logic     ev_was_act;

    assign ev_cls = out_cls_e'(ev_class);
    assign ev_ok  = ev_valid && (ev_cls != CLS_NONE) &&
                    ({1'b0, ev_src} < (SRC_W+1)'(N_SRC));

    always_comb begin
        ev_was_act = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            ev_hit[i] = ev_ok && (ev_src == SRC_W'(i));
            if (ev_hit[i]) ev_was_act = act_q[i];
        end
    end

    assign tpr_nx = tpr_we ? prio_t'(tpr_wdata[PRIO_W-1:0]) : tpr_q;

    // ---------------- next-state sets ----------------
    always_comb begin
        raised_nx = raised_q;
        act_nx    = act_q;
        prio_nx   = prio_q;
        for (int i = 0; i < N_SRC; i++) begin
            if (ev_hit[i]) begin
                act_nx[i] = ev_active;
                if (ev_cls == CLS_NORM) begin
                    raised_nx[i]                  = ev_active;
                    prio_nx[i*PRIO_W +: PRIO_W]   = ev_prio;
                end
            end
        end
    end

    // ---------------- priority search ----------------
    logic             rsd_vld, svc_vld;
    logic [SRC_W-1:0] rsd_idx, svc_idx;
    prio_t            rsd_pri, svc_pri;

    irq_prio_pick #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_pick_raised (
        .map        (raised_nx),
        .prio_flat  (prio_nx),
        .best_valid (rsd_vld),
        .best_idx   (rsd_idx),
        .best_prio  (rsd_pri)
    );

    irq_prio_pick #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_pick_svc (
        .map        (svc_map),
        .prio_flat  (prio_q),
        .best_valid (svc_vld),
        .best_idx   (svc_idx),
        .best_prio  (svc_pri)
    );

    // ---------------- normal line decision ----------------
    norm_dec_e dec;

    always_comb begin
        dec = NDEC_HOLD;
        if (ev_ok && ev_cls == CLS_NORM) begin
            if (ev_active) dec = act_decide(prio_t'(ev_prio), svc_vld, svc_pri, tpr_nx, rsd_pri);
            else           dec = deact_decide(rsd_pri, svc_pri, tpr_nx);
        end else if (tpr_we) begin
            dec = thr_decide(rsd_pri, svc_pri, tpr_nx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raised_q   <= '0;
            act_q      <= '0;
            prio_q     <= '0;
            tpr_q      <= TPR_RST;
            norm_q     <= 1'b0;
            next_q     <= '0;
            next_idx_q <= IDX_NONE;
        end else begin
            raised_q   <= raised_nx;
            act_q      <= act_nx;
            prio_q     <= prio_nx;
            tpr_q      <= tpr_nx;
            next_q     <= '{valid: rsd_vld, prio: rsd_pri};
            next_idx_q <= rsd_idx;
            case (dec)
                NDEC_RAISE: norm_q <= 1'b1;
                NDEC_DROP:  norm_q <= 1'b0;
                default:    norm_q <= norm_q;
            endcase
        end
    end

    // ---------------- special classes ----------------
    logic [N_SPECIAL-1:0] spec_line;

    generate
        for (genvar k = 0; k < N_SPECIAL; k++) begin : g_special
            localparam out_cls_e MY_CLS = out_cls_e'(k + 1);
            logic c_inc, c_dec;
            assign c_inc = ev_ok && (ev_cls == MY_CLS) &&  ev_active && !ev_was_act;
            assign c_dec = ev_ok && (ev_cls == MY_CLS) && !ev_active &&  ev_was_act;

            irq_class_counter #(.N_SRC(N_SRC)) u_cnt (
                .clk    (clk),
                .rst    (rst),
                .inc    (c_inc),
                .dec    (c_dec),
                .line_q (spec_line[k])
            );
        end
    endgenerate

    assign irq_norm   = norm_q;
    assign irq_crit   = spec_line[0];
    assign irq_mchk   = spec_line[1];
    assign tpr        = tpr_q;
    assign next_valid = next_q.valid;
    assign next_src   = next_idx_q;
    assign next_prio  = next_q.prio;

    // ---------------- assertions ----------------
    // R2 / R11: a rising normal line always sits above the task priority in force
    a_r2_rise_above_tpr: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_norm) |-> (next_valid && next_prio > tpr));

    // R3: a rise is never below or equal to the in-service level of that cycle
    a_r3_rise_above_svc: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_norm) |-> ($past(rsd_pri) > $past(svc_pri)));

    // R10: an ignored event leaves the raised set and activity untouched
    a_r10_ignored_event: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !ev_ok && !tpr_we) |=> (raised_q == $past(raised_q) && act_q == $past(act_q)));

    // R8: the reported index is empty-coded exactly when nothing is raised
    a_r8_empty_code: assert property (@(posedge clk) disable iff (rst)
        !next_valid |-> (next_src == IDX_NONE && next_prio == '0));

    // R1: raised set only changes with a qualified normal event
    a_r1_raised_only_by_event: assert property (@(posedge clk) disable iff (rst)
        !(ev_ok && ev_cls == CLS_NORM) |=> $stable(raised_q));

    // R6: a special-class event never moves the normal line
    a_r6_special_no_norm: assert property (@(posedge clk) disable iff (rst)
        (ev_ok && ev_cls != CLS_NORM && !tpr_we) |=> $stable(irq_norm));

endmodule

// File: tb/irq_prio_gate_tb.sv
module irq_prio_gate_tb;

    localparam int N_SRC = 24;
    localparam int SRC_W = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              ev_valid;
    logic [SRC_W-1:0]  ev_src;
    logic              ev_active;
    logic [3:0]        ev_prio;
    logic [1:0]        ev_class;
    logic              tpr_we;
    logic [7:0]        tpr_wdata;
    logic [N_SRC-1:0]  svc_map;
    logic              irq_norm, irq_crit, irq_mchk, next_valid;
    logic [3:0]        tpr, next_prio;
    logic [SRC_W-1:0]  next_src;

    always #5 clk = ~clk;

    irq_prio_gate #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_src(ev_src),
        .ev_active(ev_active), .ev_prio(ev_prio), .ev_class(ev_class),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .svc_map(svc_map),
        .irq_norm(irq_norm), .irq_crit(irq_crit), .irq_mchk(irq_mchk),
        .tpr(tpr), .next_valid(next_valid), .next_src(next_src),
        .next_prio(next_prio)
    );

    typedef struct packed {
        logic [1:0]  op;     // 1 event, 2 task-priority write
        logic [4:0]  idx;
        logic        act;
        logic [3:0]  pri;
        logic [1:0]  cls;
        logic [7:0]  wd;
        logic [23:0] svc;
        logic [16:0] exp;    // norm, crit, mchk, tpr[4], nvalid, nsrc[5], nprio[4]
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 5'd0,  1'b0, 4'd0,  2'd0, 8'h03, 24'h0, {3'b000, 4'd3, 1'b0, 5'd31, 4'd0}, 4'd5},  // R5
        '{2'd1, 5'd5,  1'b1, 4'd2,  2'd0, 8'h00, 24'h0, {3'b000, 4'd3, 1'b1, 5'd5,  4'd2}, 4'd2},  // R2 R1
        '{2'd2, 5'd0,  1'b0, 4'd0,  2'd0, 8'h01, 24'h0, {3'b100, 4'd1, 1'b1, 5'd5,  4'd2}, 4'd5},  // R5
        '{2'd1, 5'd7,  1'b1, 4'd6,  2'd0, 8'h00, 24'h000020, {3'b100, 4'd1, 1'b1, 5'd7, 4'd6}, 4'd3}, // R3
        '{2'd1, 5'd7,  1'b0, 4'd6,  2'd0, 8'h00, 24'h000020, {3'b000, 4'd1, 1'b1, 5'd5, 4'd2}, 4'd4}, // R4
        '{2'd1, 5'd9,  1'b1, 4'd2,  2'd0, 8'h00, 24'h000020, {3'b000, 4'd1, 1'b1, 5'd5, 4'd2}, 4'd3}, // R3 hidden
        '{2'd1, 5'd3,  1'b1, 4'd2,  2'd0, 8'h00, 24'h0, {3'b100, 4'd1, 1'b1, 5'd3,  4'd2}, 4'd8},  // R8 tie
        '{2'd2, 5'd0,  1'b0, 4'd0,  2'd0, 8'h02, 24'h0, {3'b000, 4'd2, 1'b1, 5'd3,  4'd2}, 4'd5},  // R5 drop
        '{2'd1, 5'd20, 1'b1, 4'd9,  2'd1, 8'h00, 24'h0, {3'b010, 4'd2, 1'b1, 5'd3,  4'd2}, 4'd6},  // R6
        '{2'd1, 5'd21, 1'b1, 4'd0,  2'd1, 8'h00, 24'h0, {3'b010, 4'd2, 1'b1, 5'd3,  4'd2}, 4'd6},  // R6
        '{2'd1, 5'd20, 1'b1, 4'd9,  2'd1, 8'h00, 24'h0, {3'b010, 4'd2, 1'b1, 5'd3,  4'd2}, 4'd7},  // R7 repeat
        '{2'd1, 5'd20, 1'b0, 4'd9,  2'd1, 8'h00, 24'h0, {3'b010, 4'd2, 1'b1, 5'd3,  4'd2}, 4'd6},  // R6
        '{2'd1, 5'd20, 1'b0, 4'd9,  2'd1, 8'h00, 24'h0, {3'b010, 4'd2, 1'b1, 5'd3,  4'd2}, 4'd7},  // R7 repeat
        '{2'd1, 5'd21, 1'b0, 4'd0,  2'd1, 8'h00, 24'h0, {3'b000, 4'd2, 1'b1, 5'd3,  4'd2}, 4'd6},  // R6
        '{2'd1, 5'd2,  1'b1, 4'd1,  2'd2, 8'h00, 24'h0, {3'b001, 4'd2, 1'b1, 5'd3,  4'd2}, 4'd6},  // R6
        '{2'd1, 5'd2,  1'b0, 4'd1,  2'd2, 8'h00, 24'h0, {3'b000, 4'd2, 1'b1, 5'd3,  4'd2}, 4'd6},  // R6
        '{2'd2, 5'd0,  1'b0, 4'd0,  2'd0, 8'h13, 24'h0, {3'b000, 4'd3, 1'b1, 5'd3,  4'd2}, 4'd5},  // R5 low bits
        '{2'd2, 5'd0,  1'b0, 4'd0,  2'd0, 8'h00, 24'h0, {3'b100, 4'd0, 1'b1, 5'd3,  4'd2}, 4'd5},  // R5 raise
        '{2'd2, 5'd0,  1'b0, 4'd0,  2'd0, 8'h00, 24'h000008, {3'b100, 4'd0, 1'b1, 5'd3, 4'd2}, 4'd5}, // R5 hold
        '{2'd1, 5'd30, 1'b1, 4'd15, 2'd0, 8'h00, 24'h0, {3'b100, 4'd0, 1'b1, 5'd3,  4'd2}, 4'd10}, // R10 index
        '{2'd1, 5'd4,  1'b1, 4'd15, 2'd3, 8'h00, 24'h0, {3'b100, 4'd0, 1'b1, 5'd3,  4'd2}, 4'd10}, // R10 class
        '{2'd1, 5'd3,  1'b0, 4'd2,  2'd0, 8'h00, 24'h0, {3'b100, 4'd0, 1'b1, 5'd5,  4'd2}, 4'd4},  // R4 hold
        '{2'd1, 5'd5,  1'b0, 4'd2,  2'd0, 8'h00, 24'h0, {3'b100, 4'd0, 1'b1, 5'd9,  4'd2}, 4'd1},  // R1 removal
        '{2'd1, 5'd9,  1'b0, 4'd2,  2'd0, 8'h00, 24'h0, {3'b000, 4'd0, 1'b0, 5'd31, 4'd0}, 4'd8}   // R8 empty
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    function automatic logic [16:0] observed();
        return {irq_norm, irq_crit, irq_mchk, tpr, next_valid, next_src, next_prio};
    endfunction

    task automatic check(input logic [16:0] expv, input string tag);
        logic [16:0] got;
        got = observed();
        n_checks++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    task automatic idle_inputs();
        ev_valid = 1'b0; ev_src = '0; ev_active = 1'b0; ev_prio = '0;
        ev_class = '0; tpr_we = 1'b0; tpr_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle_inputs();
        svc_map = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        svc_map = '0;
        do_reset();
        // R9: reset state
        check({3'b000, 4'd15, 1'b0, 5'd31, 4'd0}, "R9 reset state");

        for (int v = 0; v < NV; v++) begin
            idle_inputs();
            svc_map = VECS[v].svc;
            if (VECS[v].op == 2'd1) begin
                ev_valid = 1'b1; ev_src = VECS[v].idx; ev_active = VECS[v].act;
                ev_prio = VECS[v].pri; ev_class = VECS[v].cls;
            end else if (VECS[v].op == 2'd2) begin
                tpr_we = 1'b1; tpr_wdata = VECS[v].wd;
            end
            @(negedge clk);
            check(VECS[v].exp, $sformatf("R%0d vector %0d", VECS[v].req, v));
        end
        idle_inputs();
        svc_map = '0;

        // R11: event and threshold write together; decision uses new value 5
        ev_valid = 1'b1; ev_src = 5'd1; ev_active = 1'b1; ev_prio = 4'd5; ev_class = 2'd0;
        tpr_we = 1'b1; tpr_wdata = 8'h05;
        @(negedge clk);
        check({3'b000, 4'd5, 1'b1, 5'd1, 4'd5}, "R11 same-cycle write");
        idle_inputs();
        // R5: lowering the threshold below a held source raises the line
        tpr_we = 1'b1; tpr_wdata = 8'h04;
        @(negedge clk);
        check({3'b100, 4'd4, 1'b1, 5'd1, 4'd5}, "R5 release by lower threshold");
        idle_inputs();
        // R11: idle cycle leaves registered outputs unchanged
        @(negedge clk);
        check({3'b100, 4'd4, 1'b1, 5'd1, 4'd5}, "R11 idle hold");

        // R9: reset mid-run clears everything
        ev_valid = 1'b1; ev_src = 5'd6; ev_active = 1'b1; ev_class = 2'd1;
        @(negedge clk);
        idle_inputs();
        do_reset();
        check({3'b000, 4'd15, 1'b0, 5'd31, 4'd0}, "R9 reset after activity");

        // R2: with threshold 15 nothing raises the normal line
        ev_valid = 1'b1; ev_src = 5'd0; ev_active = 1'b1; ev_prio = 4'd15; ev_class = 2'd0;
        @(negedge clk);
        idle_inputs();
        check({3'b000, 4'd15, 1'b1, 5'd0, 4'd15}, "R2 at threshold 15");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule